// File: doc/BRIEF.md
# Receive Character Assembler with Overspeed Tolerance

This block sits behind a demodulator and a bit-timing recovery stage. It takes one received bit for each strobe and builds characters for a register that the host reads. In synchronous mode it packs every eight bits into one byte. In start-stop mode it waits for a start bit and collects 5 to 8 data bits. It then takes an optional parity bit and checks a single stop bit. Each stored character updates an even-parity flag and a framing-error flag.

Faster senders may drop a stop bit now and then. The block can tolerate this: a missing stop bit is accepted without error if no earlier accepted miss lies within the last 8 characters, or within the last 4, depending on the option chosen. An accepted missing stop bit is taken as the start bit of the next character. A character that is zero in every position is always a framing error, so a line break is never mistaken for data. After any framing error the receiver ignores the line until it sees a 1 followed by a 0.

The host reads the byte and pulses `rd_strobe`. That clears the ready and overflow flags. A new character that arrives before the read sets the overflow flag.

Top module: `rxchar_top`

## Requirements
- R1: After reset, `rx_data`, `data_rdy`, `overflow`, `frm_err` and `par_even` are all 0. In start-stop mode the receiver accepts a start bit only after it has first seen a 1 on the line.
- R2: With `sync_mode`=1, every 8 strobed bits are stored into `rx_data` and set `data_rdy`. The first bit received becomes bit 0.
- R3: With `sync_mode`=0, a character has this form: a 0 start bit, then 5+`cfg_len` data bits with the least significant bit first, then a parity bit if `cfg_par_en`=1, then one stop bit. The data is stored right-aligned in `rx_data` and the unused upper bits are 0. The store happens on the strobe of the stop bit.
- R4: On each start-stop store, `par_even` becomes 1 when the data bits, together with the parity bit if it is enabled, hold an even number of ones. Otherwise it becomes 0.
- R5: A stop bit received as 0 still stores the character and sets `data_rdy`. On every start-stop store, `frm_err` is set to 1 for a missing stop bit that is not accepted, and to 0 otherwise.
- R6: `cfg_ovs` selects the tolerance. 0 or 3 accepts no missing stop bit. 1 accepts a miss if none of the previous 7 characters had an accepted miss. 2 accepts a miss if none of the previous 3 had one. When a miss is accepted, the stop-position bit counts as the start of the next character.
- R7: A character whose data bits, parity bit (if enabled) and stop bit are all 0 always sets `frm_err`, even when the tolerance would otherwise accept it.
- R8: After a framing error, the receiver ignores 0 bits until a 1 arrives. The next 0 after that 1 is the start bit.
- R9: A store while `data_rdy` is still 1 sets `overflow`. A `rd_strobe` clears both `data_rdy` and `overflow`.
- R10: Between stores, `rx_data`, `frm_err` and `par_even` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` holds a received bit |
| bit_in | input | 1 | Received bit value |
| sync_mode | input | 1 | 1 = synchronous byte packing, 0 = start-stop |
| cfg_len | input | 2 | Number of data bits minus 5 |
| cfg_par_en | input | 1 | A parity bit follows the data bits |
| cfg_ovs | input | 2 | Missing-stop tolerance: 0/3 none, 1 one in 8, 2 one in 4 |
| rd_strobe | input | 1 | Host read of the data register |
| rx_data | output | 8 | Last stored character |
| data_rdy | output | 1 | An unread character is present |
| overflow | output | 1 | A character was stored over an unread one |
| frm_err | output | 1 | The last start-stop character had a framing error |
| par_even | output | 1 | Even-parity result of the last start-stop character |

## Verification
A table of characters is run with the one-in-8 tolerance. It mixes good stop bits, an accepted miss followed directly by data with no separate start bit, a miss that comes too soon and must be refused, and a miss accepted again once the window has slid past the first one. Together these separate a correct sliding window from a counter that never expires or never counts. Directed cases cover the following:
- the one-in-4 window and the no-tolerance setting;
- an all-zero break sent while the tolerance would allow a miss, followed by stray zeros that must not be taken as a start;
- a 5-bit character without parity;
- two synchronous bytes;
- an overflow and its clearing by a read.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    ST_SEEK1 = 3'd0,
    ST_IDLE  = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rxu_state_e;

  localparam logic [1:0] OVS_NONE  = 2'd0;
  localparam logic [1:0] OVS_LONG  = 2'd1;
  localparam logic [1:0] OVS_SHORT = 2'd2;
endpackage

// File: rtl/rxu_history.sv
module rxu_history #(
  parameter int WIN_LONG  = 8,
  parameter int WIN_SHORT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       push_val,
  input  logic [1:0] ovs,
  output logic       allow
);
  import rxu_pkg::*;
  localparam int HW = WIN_LONG - 1;
  localparam logic [HW-1:0] MASK_S = HW'((1 << (WIN_SHORT - 1)) - 1);

  logic [HW-1:0] hist_q, hist_n;

  always_comb begin
    hist_n = hist_q;
    if (push) hist_n = {hist_q[HW-2:0], push_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  always_comb begin
    case (ovs)
      OVS_LONG:  allow = ~|hist_q;
      OVS_SHORT: allow = ~|(hist_q & MASK_S);
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxu_framer.sv
module rxu_framer #(
  parameter int DW       = 8,
  parameter int LEN_BASE = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          sync_mode,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          allow,
  output logic          store,
  output logic          store_sync,
  output logic [DW-1:0] store_data,
  output logic          store_ferr,
  output logic          store_pev,
  output logic          hist_push,
  output logic          hist_val
);
  import rxu_pkg::*;
  localparam int CW = $clog2(DW);
  localparam logic [CW:0] DW_L = (CW+1)'(DW);
  localparam logic [CW:0] BASE_L = (CW+1)'(LEN_BASE);

  rxu_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          par_q, par_n;
  logic [CW:0]   nbits;
  logic [DW-1:0] aligned;
  logic          all_zero;

  assign nbits    = BASE_L + {{(CW-1){1'b0}}, cfg_len};
  assign aligned  = sh_q >> (DW_L - nbits);
  assign all_zero = (aligned == '0) && !(cfg_par_en && par_q) && !bit_in;

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    par_n      = par_q;
    store      = 1'b0;
    store_sync = sync_mode;
    store_data = aligned;
    store_ferr = 1'b0;
    store_pev  = ~(^aligned ^ (cfg_par_en & par_q));
    hist_push  = 1'b0;
    hist_val   = 1'b0;
    if (bit_vld) begin
      if (sync_mode) begin
        sh_n  = {bit_in, sh_q[DW-1:1]};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CW'(DW - 1)) begin
          store      = 1'b1;
          store_data = sh_n;
          cnt_n      = '0;
        end
      end else begin
        case (st_q)
          ST_SEEK1: if (bit_in) st_n = ST_IDLE;
          ST_IDLE: if (!bit_in) begin
            st_n  = ST_DATA;
            cnt_n = '0;
          end
          ST_DATA: begin
            sh_n  = {bit_in, sh_q[DW-1:1]};
            cnt_n = cnt_q + 1'b1;
            if ({1'b0, cnt_q} == nbits - 1'b1) st_n = cfg_par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            par_n = bit_in;
            st_n  = ST_STOP;
          end
          ST_STOP: begin
            store     = 1'b1;
            hist_push = 1'b1;
            if (bit_in) begin
              st_n = ST_IDLE;
            end else if (!all_zero && allow) begin
              hist_val = 1'b1;
              st_n     = ST_DATA;
              cnt_n    = '0;
            end else begin
              store_ferr = 1'b1;
              st_n       = ST_SEEK1;
            end
          end
          default: st_n = ST_SEEK1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SEEK1;
      cnt_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      par_q <= par_n;
    end
  end
endmodule

// File: rtl/rxu_status.sv
module rxu_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store,
  input  logic          store_sync,
  input  logic [DW-1:0] store_data,
  input  logic          store_ferr,
  input  logic          store_pev,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_data,
  output logic          data_rdy,
  output logic          overflow,
  output logic          frm_err,
  output logic          par_even
);
  logic [DW-1:0] dat_n;
  logic          rdy_n, ovf_n, fe_n, pe_n;

  always_comb begin
    dat_n = rx_data;
    rdy_n = data_rdy;
    ovf_n = overflow;
    fe_n  = frm_err;
    pe_n  = par_even;
    if (rd_strobe) begin
      rdy_n = 1'b0;
      ovf_n = 1'b0;
    end
    if (store) begin
      dat_n = store_data;
      rdy_n = 1'b1;
      ovf_n = (data_rdy && !rd_strobe) || (overflow && !rd_strobe);
      if (!store_sync) begin
        fe_n = store_ferr;
        pe_n = store_pev;
      end else begin
        fe_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      data_rdy <= 1'b0;
      overflow <= 1'b0;
      frm_err  <= 1'b0;
      par_even <= 1'b0;
    end else begin
      rx_data  <= dat_n;
      data_rdy <= rdy_n;
      overflow <= ovf_n;
      frm_err  <= fe_n;
      par_even <= pe_n;
    end
  end
endmodule

// File: rtl/rxchar_top.sv
module rxchar_top #(
  parameter int DW        = 8,
  parameter int LEN_BASE  = 5,
  parameter int WIN_LONG  = 8,
  parameter int WIN_SHORT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          sync_mode,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic [1:0]    cfg_ovs,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_data,
  output logic          data_rdy,
  output logic          overflow,
  output logic          frm_err,
  output logic          par_even
);
  logic          allow_w, store_w, store_sync_w, ferr_w, pev_w, hpush_w, hval_w;
  logic [DW-1:0] sdata_w;

  rxu_history #(.WIN_LONG(WIN_LONG), .WIN_SHORT(WIN_SHORT)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(hpush_w), .push_val(hval_w),
    .ovs(cfg_ovs), .allow(allow_w)
  );

  rxu_framer #(.DW(DW), .LEN_BASE(LEN_BASE)) u_frm (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .sync_mode(sync_mode), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .allow(allow_w), .store(store_w), .store_sync(store_sync_w),
    .store_data(sdata_w), .store_ferr(ferr_w), .store_pev(pev_w),
    .hist_push(hpush_w), .hist_val(hval_w)
  );

  rxu_status #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .store(store_w), .store_sync(store_sync_w),
    .store_data(sdata_w), .store_ferr(ferr_w), .store_pev(pev_w),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .data_rdy(data_rdy),
    .overflow(overflow), .frm_err(frm_err), .par_even(par_even)
  );
endmodule

// File: rtl/rxu_chk.sv
module rxu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_strobe,
  input logic          store,
  input logic [DW-1:0] rx_data,
  input logic          data_rdy,
  input logic          overflow,
  input logic          frm_err,
  input logic          par_even
);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !store |=> !data_rdy && !overflow);

  a_r5_store_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> data_rdy);

  a_r9_overflow_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> data_rdy);

  a_r9_overflow_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(data_rdy));

  a_r10_hold_between_stores: assert property (@(posedge clk) disable iff (!rst_n)
    !store |=> $stable(frm_err) && $stable(par_even) && $stable(rx_data));
endmodule

bind rxchar_top rxu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .store(store_w),
  .rx_data(rx_data), .data_rdy(data_rdy), .overflow(overflow),
  .frm_err(frm_err), .par_even(par_even)
);

// File: tb/rxchar_top_tb.sv
module rxchar_top_tb;
  localparam int CLK_P = 10;
  localparam int NV = 11;
  // {nostart, data[7:0], parbit, stop, exp_err, exp_even}, one-in-8 tolerance
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'hA3, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h81, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b0, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h12, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h34, 1'b1, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  logic clk, rst_n, bit_vld, bit_in, sync_mode, cfg_par_en, rd_strobe;
  logic [1:0] cfg_len, cfg_ovs;
  logic [7:0] rx_data;
  logic data_rdy, overflow, frm_err, par_even;
  int checks, errors, cyc;
  bit done;

  rxchar_top u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .sync_mode(sync_mode), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_ovs(cfg_ovs), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .data_rdy(data_rdy), .overflow(overflow), .frm_err(frm_err),
    .par_even(par_even)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks = checks + 1;
    if (act !== exp_v) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic do_reset(input logic sm, input logic [1:0] ln, input logic pe, input logic [1:0] ov);
    @(negedge clk);
    sync_mode = sm; cfg_len = ln; cfg_par_en = pe; cfg_ovs = ov;
    bit_vld = 0; bit_in = 1; rd_strobe = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b; bit_vld = 1;
    @(negedge clk);
    bit_vld = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int n, input logic pe,
                           input logic pb, input logic stp, input logic do_start);
    if (do_start) begin
      send_bit(1); send_bit(1); send_bit(0);
    end
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (pe) send_bit(pb);
    send_bit(stp);
  endtask

  task automatic host_read();
    @(negedge clk);
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; done = 0;
    rst_n = 0; bit_vld = 0; bit_in = 1; rd_strobe = 0;
    sync_mode = 0; cfg_len = 2'd3; cfg_par_en = 1; cfg_ovs = 2'd1;

    // R1 reset state
    do_reset(0, 2'd3, 1, 2'd1);
    chk("R1 rx_data", rx_data, 8'h00);
    chk("R1 flags", {4'b0, data_rdy, overflow, frm_err, par_even}, 8'h00);

    // Table walk: R3 R4 R5 R6 with one-in-8 tolerance
    for (int k = 0; k < NV; k++) begin
      logic [12:0] v;
      v = VEC[k];
      send_char(v[11:4], 8, 1, v[3], v[2], !v[12]);
      chk($sformatf("R3 data row %0d", k), rx_data, v[11:4]);
      chk($sformatf("R5 ready row %0d", k), {7'b0, data_rdy}, 8'h01);
      chk($sformatf("R6 frm_err row %0d", k), {7'b0, frm_err}, {7'b0, v[1]});
      chk($sformatf("R4 par_even row %0d", k), {7'b0, par_even}, {7'b0, v[0]});
      host_read();
      chk($sformatf("R9 read clears row %0d", k), {6'b0, data_rdy, overflow}, 8'h00);
    end
    // R10 nothing stored: values hold after idle bits
    send_bit(1); send_bit(1);
    chk("R10 data hold", rx_data, 8'h3C);
    chk("R10 ready stays low", {7'b0, data_rdy}, 8'h00);

    // R9 overflow
    send_char(8'h21, 8, 1, 1'b0, 1'b1, 1'b1);
    send_char(8'h42, 8, 1, 1'b0, 1'b1, 1'b1);
    chk("R9 overflow set", {6'b0, data_rdy, overflow}, 8'h03);
    chk("R9 newest data", rx_data, 8'h42);
    host_read();
    chk("R9 overflow cleared", {6'b0, data_rdy, overflow}, 8'h00);

    // R7 break with tolerance available, then R8 resync
    do_reset(0, 2'd3, 1, 2'd1);
    send_char(8'h00, 8, 1, 1'b0, 1'b0, 1'b1);
    chk("R7 break frm_err", {7'b0, frm_err}, 8'h01);
    chk("R7 break stored", {7'b0, data_rdy}, 8'h01);
    host_read();
    send_bit(0); send_bit(0); send_bit(0);
    chk("R8 zeros ignored", {7'b0, data_rdy}, 8'h00);
    send_char(8'h6B, 8, 1, 1'b1, 1'b1, 1'b1);
    chk("R8 resync data", rx_data, 8'h6B);
    chk("R8 resync frm_err", {7'b0, frm_err}, 8'h00);
    host_read();

    // R6 one-in-4 window
    do_reset(0, 2'd3, 1, 2'd2);
    send_char(8'h11, 8, 1, 1'b0, 1'b0, 1'b1);
    chk("R6 short first miss", {7'b0, frm_err}, 8'h00);
    host_read();
    send_char(8'h22, 8, 1, 1'b0, 1'b1, 1'b0);
    chk("R6 miss as start data", rx_data, 8'h22);
    host_read();
    send_char(8'h33, 8, 1, 1'b0, 1'b1, 1'b1);
    host_read();
    send_char(8'h44, 8, 1, 1'b0, 1'b0, 1'b1);
    chk("R6 short early miss", {7'b0, frm_err}, 8'h01);
    host_read();
    send_char(8'h55, 8, 1, 1'b0, 1'b1, 1'b1); host_read();
    send_char(8'h66, 8, 1, 1'b0, 1'b1, 1'b1); host_read();
    send_char(8'h77, 8, 1, 1'b0, 1'b1, 1'b1); host_read();
    send_char(8'h88, 8, 1, 1'b0, 1'b0, 1'b1);
    chk("R6 short window slid", {7'b0, frm_err}, 8'h00);
    host_read();
    send_char(8'h99, 8, 1, 1'b0, 1'b1, 1'b0);
    chk("R6 short follow data", rx_data, 8'h99);
    host_read();

    // R6 no tolerance
    do_reset(0, 2'd3, 1, 2'd0);
    send_char(8'h5A, 8, 1, 1'b0, 1'b0, 1'b1);
    chk("R6 none frm_err", {7'b0, frm_err}, 8'h01);
    chk("R5 none still stored", rx_data, 8'h5A);
    host_read();

    // R3 R4 five bits, no parity
    do_reset(0, 2'd0, 0, 2'd0);
    send_char(8'h15, 5, 0, 1'b0, 1'b1, 1'b1);
    chk("R3 five-bit data", rx_data, 8'h15);
    chk("R4 five-bit parity", {7'b0, par_even}, 8'h00);
    host_read();

    // R2 synchronous mode
    do_reset(1, 2'd3, 0, 2'd0);
    for (int i = 0; i < 8; i++) send_bit(8'hC5 >> i);
    chk("R2 sync byte 1", rx_data, 8'hC5);
    chk("R2 sync ready", {7'b0, data_rdy}, 8'h01);
    host_read();
    for (int i = 0; i < 8; i++) send_bit(8'h3A >> i);
    chk("R2 sync byte 2", rx_data, 8'h3A);
    chk("R2 sync no frm_err", {7'b0, frm_err}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule